// File: doc/BRIEF.md
# Multi-Comparator Event Timer

This block is a memory-mapped event timer built around one free-running 64-bit up-counter and three comparator channels. The counter advances by one on each clock in which the global enable is set and the tick-enable input is high. Each channel holds a match value and raises its own interrupt when the counter steps onto that value. A channel can fire once (one-shot), or it can re-arm itself on every match by adding a stored period to its match value (periodic).

Software reaches the block through a simple synchronous register bus. A write takes effect at the clock edge where the write enable is high. Read data is a combinational function of the address. Interrupts are either single-cycle pulses (edge) or held lines backed by a status bit that software clears by writing one (level). A 32-bit mode lets a channel compare only the low half of the counter.

Top module: `evt_timer`

## Requirements
- R1: After reset, address 0x000 reads a read-only capability word. Bits 63:32 hold the tick period in femtoseconds (default 10,000,000), bits 31:16 the vendor code (default 0xA5C3) and bit 15 the legacy-routing capability (default 1). Bit 14 reads 0, bit 13 reads 1 (64-bit counter), bits 12:8 hold the channel count minus one (2), and bits 7:0 the revision (0x01). The default word is 0x00989680A5C3A201.
- R2: Bit 0 of the general configuration at 0x010 is the global enable. The counter at 0x0F0 adds one per clock only while that bit and tick_en are both high. A write to 0x0F0 loads the counter.
- R3: Bit 1 of the general configuration is the legacy-routing select. It stores the written value only when the legacy capability is built in; otherwise it reads 0.
- R4: The channel n configuration word sits at 0x100+0x20*n and the comparator at 0x108+0x20*n. The configuration bits are: 1 = level trigger, 2 = interrupt enable, 3 = periodic, 4 = periodic-capable (read-only), 5 = 64-bit-capable (read-only, always 1), 6 = value-set, 8 = 32-bit mode. Channels 0 and 1 are periodic-capable and channel 2 is not. On channel 2, a write to bit 3 is ignored and the bit reads 0.
- R5: A one-shot channel fires once, in the clock after the counter steps onto its comparator value. Under continuous ticking, the counter then already reads the comparator value plus one.
- R6: A periodic channel adds its stored period to its comparator on every match and fires again at each later match.
- R7: A comparator write made while value-set is 1 also loads the period, and value-set then clears to 0. Later comparator writes change only the next match value.
- R8: In edge mode (bit 1 = 0) each match produces an interrupt pulse one clock wide.
- R9: In level mode, a match sets bit n of the status register at 0x020, and interrupt n stays high until software writes 1 to that bit.
- R10: With interrupt enable clear, a match produces neither a pulse nor a status bit.
- R11: In 32-bit mode a channel matches on the low 32 bits of the counter, and its comparator is stored zero-extended from the low 32 bits of the written data.
- R12: While the global enable is clear, the counter holds and no channel fires, even in the clock right after the counter's last step.
- R13: After reset the configuration, status and counter registers read zero and every interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advances the counter when the global enable is set |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for bus_addr (combinational) |
| irq | output | 3 | One interrupt line per channel |

## Verification
The hardest case to reach is a match that lands in the one clock after the global enable is cleared. The counter has just taken its last step, and a correct design must suppress the interrupt. The bench reaches this case by counting its own bus-write latency: it issues the disable write so that the counter's final increment lands exactly on a channel's comparator. Periodic re-arming is tested at several matches in a row, and again after a comparator write made without value-set, so that a lost or overwritten period shows up as a missing or mistimed pulse in the scoreboard.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int DW = 64;
    localparam int AW = 12;

    localparam logic [AW-1:0] OFS_CAP       = 12'h000;
    localparam logic [AW-1:0] OFS_GCFG      = 12'h010;
    localparam logic [AW-1:0] OFS_STAT      = 12'h020;
    localparam logic [AW-1:0] OFS_CNT       = 12'h0F0;
    localparam logic [AW-1:0] OFS_CH_BASE   = 12'h100;
    localparam logic [AW-1:0] OFS_CH_STRIDE = 12'h020;
    localparam logic [AW-1:0] OFS_CH_CMP    = 12'h008;

    // general configuration bit positions
    localparam int GB_EN  = 0;
    localparam int GB_LEG = 1;

    // channel configuration bit positions
    localparam int CB_LEVEL   = 1;
    localparam int CB_IE      = 2;
    localparam int CB_PER     = 3;
    localparam int CB_PERCAP  = 4;
    localparam int CB_SIZECAP = 5;
    localparam int CB_VALSET  = 6;
    localparam int CB_M32     = 8;

    typedef struct packed {
        logic mode32;
        logic valset;
        logic periodic;
        logic int_en;
        logic level;
    } chan_cfg_t;

    function automatic logic [DW-1:0] cfg_word(chan_cfg_t c, logic per_cap);
        logic [DW-1:0] w;
        w             = '0;
        w[CB_LEVEL]   = c.level;
        w[CB_IE]      = c.int_en;
        w[CB_PER]     = c.periodic;
        w[CB_PERCAP]  = per_cap;
        w[CB_SIZECAP] = 1'b1;
        w[CB_VALSET]  = c.valset;
        w[CB_M32]     = c.mode32;
        return w;
    endfunction

    function automatic logic [DW-1:0] narrow(logic [DW-1:0] v, logic m32);
        return m32 ? {{(DW-32){1'b0}}, v[31:0]} : v;
    endfunction

    function automatic logic same_value(logic [DW-1:0] a, logic [DW-1:0] b, logic m32);
        return m32 ? (a[31:0] == b[31:0]) : (a == b);
    endfunction

    function automatic logic [DW-1:0] ch_addr(int n, logic [AW-1:0] sub);
        return DW'(OFS_CH_BASE + AW'(n) * OFS_CH_STRIDE + sub);
    endfunction

endpackage

// File: rtl/evt_counter.sv
module evt_counter
    import evt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          tick_en,
    input  logic          ld,
    input  logic [DW-1:0] ld_val,
    output logic [DW-1:0] cnt,
    output logic          step
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            step <= 1'b0;
        end else begin
            step <= 1'b0;
            if (ld) begin
                cnt <= ld_val;
            end else if (run && tick_en) begin
                cnt  <= cnt + 1'b1;
                step <= 1'b1;
            end
        end
    end

    // R2: no load and no qualified tick means the count holds
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!ld && !(run && tick_en)) |=> $stable(cnt));

endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evt_pkg::*;
#(
    parameter bit PER_CAP = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          glb_en,
    input  logic          step,
    input  logic [DW-1:0] cnt,
    input  logic          cfg_we,
    input  logic          cmp_we,
    input  logic [DW-1:0] wdata,
    input  logic          st_clr,
    output logic [DW-1:0] cfg_rd,
    output logic [DW-1:0] cmp_rd,
    output logic          status,
    output logic          irq
);

    chan_cfg_t     cfg;
    logic [DW-1:0] cmp_q;
    logic [DW-1:0] period_q;
    logic          status_q;
    logic          edge_q;
    logic          hit;

    assign hit = step && glb_en && same_value(cnt, cmp_q, cfg.mode32);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            cmp_q    <= '0;
            period_q <= '0;
            status_q <= 1'b0;
            edge_q   <= 1'b0;
        end else begin
            if (cfg_we) begin
                cfg.level    <= wdata[CB_LEVEL];
                cfg.int_en   <= wdata[CB_IE];
                cfg.periodic <= PER_CAP & wdata[CB_PER];
                cfg.valset   <= wdata[CB_VALSET];
                cfg.mode32   <= wdata[CB_M32];
            end else if (cmp_we && cfg.valset) begin
                cfg.valset <= 1'b0;
            end

            if (cmp_we) begin
                cmp_q <= narrow(wdata, cfg.mode32);
                if (cfg.valset)
                    period_q <= narrow(wdata, cfg.mode32);
            end else if (hit && cfg.periodic) begin
                cmp_q <= narrow(cmp_q + period_q, cfg.mode32);
            end

            edge_q <= hit && cfg.int_en && !cfg.level;

            if (hit && cfg.int_en && cfg.level)
                status_q <= 1'b1;
            else if (st_clr)
                status_q <= 1'b0;
        end
    end

    assign cfg_rd = cfg_word(cfg, PER_CAP);
    assign cmp_rd = cmp_q;
    assign status = status_q;
    assign irq    = cfg.level ? (status_q && cfg.int_en) : edge_q;

    // R4: a channel without periodic capability never holds periodic mode
    assert_no_periodic_R4: assert property (@(posedge clk) disable iff (rst)
        !PER_CAP |-> !cfg.periodic);

    // R5: a one-shot match leaves the comparator untouched
    assert_oneshot_keep_R5: assert property (@(posedge clk) disable iff (rst)
        (hit && !cfg.periodic && !cmp_we && !cfg_we) |=> $stable(cmp_q));

    // R6: a periodic match advances the comparator by the stored period
    assert_periodic_step_R6: assert property (@(posedge clk) disable iff (rst)
        (hit && cfg.periodic && !cmp_we && !cfg_we) |=>
        (cmp_q == narrow($past(cmp_q) + period_q, cfg.mode32)));

    // R7: value-set drops after the comparator write it qualified
    assert_valset_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (cmp_we && cfg.valset) |=> !cfg.valset);

    // R9: a level status bit holds until a clear is written
    assert_status_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (status_q && !st_clr) |=> status_q);

    // R10: interrupt enable off means no edge pulse next cycle
    assert_gate_ie_R10: assert property (@(posedge clk) disable iff (rst)
        (!cfg.int_en && !cfg_we) |=> !edge_q);

    // R12: no pulse follows a cycle with the global enable off
    assert_quiet_off_R12: assert property (@(posedge clk) disable iff (rst)
        !glb_en |=> !edge_q);

endmodule

// File: rtl/evt_readmux.sv
module evt_readmux
    import evt_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic [AW-1:0]           addr,
    input  logic [DW-1:0]           cap,
    input  logic [DW-1:0]           gcfg,
    input  logic [NCH-1:0]          status,
    input  logic [DW-1:0]           cnt,
    input  logic [NCH-1:0][DW-1:0]  cfg_rd,
    input  logic [NCH-1:0][DW-1:0]  cmp_rd,
    output logic [DW-1:0]           rdata
);

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_CAP:  rdata = cap;
            OFS_GCFG: rdata = gcfg;
            OFS_STAT: rdata = DW'(status);
            OFS_CNT:  rdata = cnt;
            default:  rdata = '0;
        endcase
        for (int i = 0; i < NCH; i++) begin
            if (DW'(addr) == ch_addr(i, '0))         rdata = cfg_rd[i];
            if (DW'(addr) == ch_addr(i, OFS_CH_CMP)) rdata = cmp_rd[i];
        end
    end

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_pkg::*;
#(
    parameter int          NCH          = 3,
    parameter logic [31:0] PERIOD_FS    = 32'd10_000_000,
    parameter logic [15:0] VENDOR       = 16'hA5C3,
    parameter logic [7:0]  REVISION     = 8'h01,
    parameter bit          LEGACY_CAP   = 1'b1,
    parameter logic [NCH-1:0] PER_CAP_MASK = 3'b011
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick_en,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_we,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] irq
);

    localparam logic [DW-1:0] CAP_WORD =
        {PERIOD_FS, VENDOR, LEGACY_CAP, 1'b0, 1'b1, 5'(NCH - 1), REVISION};

    logic                  glb_en;
    logic                  glb_leg;
    logic [DW-1:0]         cnt;
    logic                  step;
    logic [NCH-1:0]        status;
    logic [NCH-1:0][DW-1:0] cfg_rd;
    logic [NCH-1:0][DW-1:0] cmp_rd;
    logic                  stat_we;

    assign stat_we = bus_we && (bus_addr == OFS_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            glb_en  <= 1'b0;
            glb_leg <= 1'b0;
        end else if (bus_we && bus_addr == OFS_GCFG) begin
            glb_en  <= bus_wdata[GB_EN];
            glb_leg <= LEGACY_CAP & bus_wdata[GB_LEG];
        end
    end

    evt_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run     (glb_en),
        .tick_en (tick_en),
        .ld      (bus_we && bus_addr == OFS_CNT),
        .ld_val  (bus_wdata),
        .cnt     (cnt),
        .step    (step)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        evt_channel #(.PER_CAP(PER_CAP_MASK[n])) u_ch (
            .clk    (clk),
            .rst    (rst),
            .glb_en (glb_en),
            .step   (step),
            .cnt    (cnt),
            .cfg_we (bus_we && DW'(bus_addr) == ch_addr(n, '0)),
            .cmp_we (bus_we && DW'(bus_addr) == ch_addr(n, OFS_CH_CMP)),
            .wdata  (bus_wdata),
            .st_clr (stat_we && bus_wdata[n]),
            .cfg_rd (cfg_rd[n]),
            .cmp_rd (cmp_rd[n]),
            .status (status[n]),
            .irq    (irq[n])
        );
    end

    evt_readmux #(.NCH(NCH)) u_rd (
        .addr   (bus_addr),
        .cap    (CAP_WORD),
        .gcfg   ({{(DW-2){1'b0}}, glb_leg, glb_en}),
        .status (status),
        .cnt    (cnt),
        .cfg_rd (cfg_rd),
        .cmp_rd (cmp_rd),
        .rdata  (bus_rdata)
    );

    // R3: legacy select can only be set when the capability exists
    assert_legacy_gate_R3: assert property (@(posedge clk) disable iff (rst)
        !LEGACY_CAP |-> !glb_leg);

endmodule

// File: tb/evt_timer_tb.sv
module evt_timer_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick_en;
    logic [11:0] addr;
    logic        we;
    logic [63:0] wdata;
    logic [63:0] rdata;
    logic [2:0]  irq;

    always #5 clk = ~clk;

    evt_timer u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(addr),
        .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // independent reference counter built from R2
    logic        m_en;
    logic [63:0] m_cnt;
    always @(posedge clk) begin
        if (rst) begin
            m_en  <= 1'b0;
            m_cnt <= '0;
        end else begin
            if (we && addr == 12'h010) m_en <= wdata[0];
            if (we && addr == 12'h0F0) m_cnt <= wdata;
            else if (m_en && tick_en)  m_cnt <= m_cnt + 1;
        end
    end

    // scoreboard: expected interrupt rises, tagged with the count seen then
    typedef struct { int ch; logic [63:0] at; } exp_t;
    exp_t q[$];
    exp_t e_cur;
    logic [2:0] lvl_mode = '0;
    logic [2:0] prev_irq = '0;
    logic [2:0] edge_watch = '0;

    task automatic expect_irq(int ch, logic [63:0] at);
        exp_t e;
        e.ch = ch;
        e.at = at;
        q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            for (int c = 0; c < 3; c++) begin
                if (edge_watch[c]) chk("R8 pulse width", 64'(irq[c]), 64'd0);
                edge_watch[c] = 1'b0;
                if (irq[c] && !prev_irq[c]) begin
                    if (q.size() == 0) begin
                        chk("R10/R12 unexpected interrupt", 64'(c), 64'hFFFF);
                    end else begin
                        e_cur = q.pop_front();
                        chk("R5/R6 interrupt channel", 64'(c), 64'(e_cur.ch));
                        chk("R5/R6 interrupt timing", m_cnt, e_cur.at);
                    end
                    edge_watch[c] = !lvl_mode[c];
                end
            end
        end
        prev_irq = irq;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            chk("watchdog", 64'd0, 64'd1);
            report();
        end
    end

    task automatic wr(logic [11:0] a, logic [63:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [63:0] d);
        @(negedge clk);
        addr = a; we = 1'b0;
        #1 d = rdata;
    endtask

    task automatic run_to(logic [63:0] v);
        while (m_cnt != v) @(negedge clk);
    endtask

    task automatic queue_empty(string tag);
        chk(tag, 64'(q.size()), 64'd0);
    endtask

    logic [63:0] v;

    initial begin
        rst = 1'b1; tick_en = 1'b1; addr = '0; we = 1'b0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        rd(12'h000, v); chk("R1 capability word", v, 64'h00989680_A5C3A201);
        rd(12'h010, v); chk("R13 config reset", v, 64'd0);
        rd(12'h020, v); chk("R13 status reset", v, 64'd0);
        rd(12'h0F0, v); chk("R13 counter reset", v, 64'd0);
        rd(12'h100, v); chk("R13 channel0 config reset", v, 64'h30);
        chk("R13 irq reset", 64'(irq), 64'd0);

        // legacy select stored (capability present), counter halted
        wr(12'h010, 64'h2);
        rd(12'h010, v); chk("R3 legacy readback", v, 64'h2);
        wr(12'h0F0, 64'd0);
        repeat (5) @(negedge clk);
        rd(12'h0F0, v); chk("R2 counter halted", v, 64'd0);
        wr(12'h000, 64'hFFFF);
        rd(12'h000, v); chk("R1 capability read-only", v, 64'h00989680_A5C3A201);

        // channel setup: ch0 one-shot, ch1 periodic with value-set
        wr(12'h100, 64'h4);
        wr(12'h108, 64'd20);
        wr(12'h120, 64'h4C);
        wr(12'h128, 64'd10);
        rd(12'h120, v); chk("R7 value-set cleared", v, 64'h3C);
        wr(12'h140, 64'h4C);
        rd(12'h140, v); chk("R4 periodic ignored on channel 2", v, 64'h64);
        wr(12'h140, 64'h0);

        expect_irq(1, 11); expect_irq(0, 21); expect_irq(1, 21); expect_irq(1, 31);
        wr(12'h010, 64'h3);
        run_to(38);
        wr(12'h010, 64'h2);
        rd(12'h0F0, v); chk("R2 counter after disable", v, 64'd40);
        queue_empty("R5/R6 all matches seen");

        // plain comparator write keeps the period (R7)
        wr(12'h128, 64'd50);
        expect_irq(1, 51); expect_irq(1, 61);
        wr(12'h010, 64'h3);
        run_to(62);
        wr(12'h010, 64'h2);
        queue_empty("R7 period retained");

        // level mode on channel 2, with a tick gap
        wr(12'h120, 64'h0);
        lvl_mode[2] = 1'b1;
        wr(12'h140, 64'h6);
        wr(12'h148, 64'd70);
        expect_irq(2, 71);
        wr(12'h010, 64'h3);
        run_to(66);
        tick_en = 1'b0;
        repeat (5) @(negedge clk);
        rd(12'h0F0, v); chk("R2 tick gap holds count", v, 64'd66);
        tick_en = 1'b1;
        run_to(74);
        wr(12'h010, 64'h2);
        queue_empty("R9 level interrupt seen");
        rd(12'h020, v); chk("R9 status set", v, 64'h4);
        chk("R9 irq held", 64'(irq[2]), 64'd1);
        wr(12'h020, 64'h4);
        rd(12'h020, v); chk("R9 status cleared", v, 64'd0);
        chk("R9 irq released", 64'(irq[2]), 64'd0);

        // level match with interrupt enable off
        wr(12'h140, 64'h2);
        wr(12'h148, 64'd80);
        wr(12'h010, 64'h3);
        run_to(84);
        wr(12'h010, 64'h2);
        rd(12'h020, v); chk("R10 no status without enable", v, 64'd0);
        chk("R10 no irq without enable", 64'(irq), 64'd0);

        // 32-bit mode on ch0; ch2 edge match on the disable step (R12)
        lvl_mode[2] = 1'b0;
        wr(12'h100, 64'h104);
        wr(12'h0F0, 64'h1_0000_0020);
        wr(12'h108, 64'hFFFF_FFFF_0000_0030);
        rd(12'h108, v); chk("R11 comparator zero-extended", v, 64'h30);
        rd(12'h100, v); chk("R4 channel0 config layout", v, 64'h134);
        wr(12'h140, 64'h104);
        wr(12'h148, 64'h36);
        expect_irq(0, 64'h1_0000_0031);
        wr(12'h010, 64'h3);
        run_to(64'h1_0000_0034);
        wr(12'h010, 64'h2);
        repeat (4) @(negedge clk);
        chk("R12 no fire after disable", 64'(irq), 64'd0);
        rd(12'h0F0, v); chk("R12 counter held", v, 64'h1_0000_0036);
        queue_empty("R11 low-half match seen");

        report();
    end

endmodule